// File: doc/BRIEF.md
# Shader Core Thread-Block Admission Controller

This block keeps the resource ledger of one shader core. It decides whether another thread block fits on the core, and records that block when it is placed. The ledger holds four running totals: occupied thread slots, shared-memory bytes, registers and resident blocks. A placement request gives the block's thread count, its shared-memory need and its per-thread register count. A mode bit selects a dry-run probe or a commit. The padded thread span goes out to an external slot finder. That finder answers with a single bit that says whether a contiguous run of free slots of that span exists.

The verdict is combinational from the request, the finder's answer and the current totals. A commit that is accepted updates the totals on the next clock edge. A release port returns the resources of a finished block. It removes exactly what a commit with the same parameters added. A release that would drive any total below zero is dropped as a whole, and it raises a sticky error flag. Neither port has back-pressure: each presents at most one request per cycle, and the controller takes it in that cycle. The two ports may be active in the same cycle.

Top module: `sm_block_admit`

## Requirements
- R1: `req_span` equals `req_threads` rounded up to the next multiple of `WARP` (a power of two, default 32). A count that is already a multiple is unchanged.
- R2: A request is rejected when `occ_threads` plus `req_span` exceeds `THREAD_CAP`.
- R3: A request is rejected whenever `slot_free` is low.
- R4: A request is rejected when `occ_smem` plus `req_smem` exceeds `SMEM_CAP`.
- R5: Register demand is `req_span` times (`req_rpt` rounded up to a multiple of 4). A request is rejected when `occ_regs` plus this demand exceeds `REG_CAP`.
- R6: A request is rejected when `occ_blocks` plus one exceeds `BLK_CAP`.
- R7: `req_ok` is 1 exactly when `req_valid` is high and none of the checks in R2 to R6 rejects the request. With `req_mode` = 0 (probe), all four totals stay unchanged.
- R8: With `req_mode` = 1 (commit) and `req_ok` high, the next edge adds the padded threads, the shared memory, the register demand and one block to the totals.
- R9: A release (`rel_valid`) subtracts, on the next edge, the padded thread span, the shared memory, the register demand (computed as in R1 and R5) and one block.
- R10: A release for which any total is smaller than the amount to remove changes no total and sets `err_underflow`. The flag stays set until reset.
- R11: When an accepted commit and a valid release occur in the same cycle, both take effect on that edge. Acceptance is judged against the totals before the release.
- R12: After reset all four totals are 0 and `err_underflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Placement request present |
| req_mode | input | 1 | 0 = probe only, 1 = commit if accepted |
| req_threads | input | TCW | Requested thread count |
| req_smem | input | SMW | Requested shared-memory bytes |
| req_rpt | input | RPT_W | Registers per thread |
| req_span | output | TCW+1 | Padded thread span, sent to the slot finder |
| slot_free | input | 1 | Slot finder: a contiguous free run of `req_span` exists |
| req_ok | output | 1 | Request accepted (combinational) |
| rel_valid | input | 1 | Release of a finished block |
| rel_threads | input | TCW | Thread count of the released block |
| rel_smem | input | SMW | Shared memory of the released block |
| rel_rpt | input | RPT_W | Registers per thread of the released block |
| occ_threads | output | TCW | Occupied thread slots |
| occ_smem | output | SMW | Occupied shared memory |
| occ_regs | output | RGW | Occupied registers |
| occ_blocks | output | BKW | Resident blocks |
| err_underflow | output | 1 | Sticky release-underflow flag |

## Verification
The assertions assume that the slot finder's answer and every request field are stable from the first point in a cycle until the clock edge. They also assume that each parameter fits its port width. The stimulus drives all inputs only at the falling edge. During the random phase it releases only blocks it committed earlier, which it keeps in a small pool, so underflow cannot occur there. The single deliberate underflow is issued at the very end, once the pool is empty, because the flag is sticky.

// File: rtl/ba_pkg.sv
package ba_pkg;
  typedef enum logic {
    MODE_PROBE  = 1'b0,
    MODE_COMMIT = 1'b1
  } ba_mode_e;

  typedef enum int unsigned {
    RES_THR  = 0,
    RES_SMEM = 1,
    RES_REG  = 2,
    RES_BLK  = 3
  } ba_res_e;

  localparam int unsigned NRES = 4;
endpackage

// File: rtl/ba_pad.sv
module ba_pad #(
  parameter int unsigned WARP = 32,
  parameter int unsigned TW   = 12,
  parameter int unsigned RPW  = 8,
  localparam int unsigned DW  = TW + RPW + 2
) (
  input  logic [TW-1:0]  thr,
  input  logic [RPW-1:0] rpt,
  output logic [TW:0]    span,
  output logic [DW-1:0]  regs
);
  logic [TW:0]  sum;
  logic [RPW:0] rpt_pad;

  assign sum     = {1'b0, thr} + (TW+1)'(WARP - 1);
  assign rpt_pad = ({1'b0, rpt} + (RPW+1)'(3)) & ~(RPW+1)'(3);

  generate
    if ((WARP & (WARP - 1)) == 0) begin : g_mask
      assign span = sum & ~(TW+1)'(WARP - 1);
    end else begin : g_div
      assign span = (TW+1)'((sum / (TW+1)'(WARP)) * (TW+1)'(WARP));
    end
  endgenerate

  assign regs = DW'(span) * DW'(rpt_pad);
endmodule

// File: rtl/ba_ledger.sv
module ba_ledger #(
  parameter int unsigned OW  = 12,
  parameter int unsigned AW  = 13,
  parameter int unsigned CAP = 2048,
  localparam int unsigned MW = ((OW > AW) ? OW : AW) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] add,
  input  logic [AW-1:0] sub,
  input  logic          do_add,
  input  logic          do_sub,
  output logic          fits,
  output logic          short,
  output logic [OW-1:0] occ
);
  logic [MW-1:0] nxt;

  assign fits  = (MW'(occ) + MW'(add)) <= MW'(CAP);
  assign short = MW'(occ) < MW'(sub);
  assign nxt   = MW'(occ) + (do_add ? MW'(add) : '0) - (do_sub ? MW'(sub) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= nxt[OW-1:0];
  end
endmodule

// File: rtl/sm_block_admit.sv
module sm_block_admit #(
  parameter int unsigned WARP       = 32,
  parameter int unsigned THREAD_CAP = 2048,
  parameter int unsigned SMEM_CAP   = 65536,
  parameter int unsigned REG_CAP    = 65536,
  parameter int unsigned BLK_CAP    = 32,
  parameter int unsigned RPT_W      = 8,
  localparam int unsigned TCW = $clog2(THREAD_CAP + 1),
  localparam int unsigned SMW = $clog2(SMEM_CAP + 1),
  localparam int unsigned RGW = $clog2(REG_CAP + 1),
  localparam int unsigned BKW = $clog2(BLK_CAP + 1),
  localparam int unsigned DW  = TCW + RPT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_mode,
  input  logic [TCW-1:0]   req_threads,
  input  logic [SMW-1:0]   req_smem,
  input  logic [RPT_W-1:0] req_rpt,
  output logic [TCW:0]     req_span,
  input  logic             slot_free,
  output logic             req_ok,
  input  logic             rel_valid,
  input  logic [TCW-1:0]   rel_threads,
  input  logic [SMW-1:0]   rel_smem,
  input  logic [RPT_W-1:0] rel_rpt,
  output logic [TCW-1:0]   occ_threads,
  output logic [SMW-1:0]   occ_smem,
  output logic [RGW-1:0]   occ_regs,
  output logic [BKW-1:0]   occ_blocks,
  output logic             err_underflow
);
  import ba_pkg::*;

  logic [TCW:0]          rel_span;
  logic [DW-1:0]         req_regs, rel_regs;
  logic [NRES-1:0]       fits, short;
  logic                  do_add, do_sub, rel_bad;

  ba_pad #(.WARP(WARP), .TW(TCW), .RPW(RPT_W)) u_pad_req (
    .thr(req_threads), .rpt(req_rpt), .span(req_span), .regs(req_regs));

  ba_pad #(.WARP(WARP), .TW(TCW), .RPW(RPT_W)) u_pad_rel (
    .thr(rel_threads), .rpt(rel_rpt), .span(rel_span), .regs(rel_regs));

  assign req_ok  = req_valid & slot_free & (&fits);
  assign do_add  = req_ok & (req_mode == MODE_COMMIT);
  assign rel_bad = rel_valid & (|short);
  assign do_sub  = rel_valid & ~(|short);

  ba_ledger #(.OW(TCW), .AW(TCW+1), .CAP(THREAD_CAP)) u_thr (
    .clk(clk), .rst_n(rst_n), .add(req_span), .sub(rel_span),
    .do_add(do_add), .do_sub(do_sub),
    .fits(fits[RES_THR]), .short(short[RES_THR]), .occ(occ_threads));

  ba_ledger #(.OW(SMW), .AW(SMW), .CAP(SMEM_CAP)) u_smem (
    .clk(clk), .rst_n(rst_n), .add(req_smem), .sub(rel_smem),
    .do_add(do_add), .do_sub(do_sub),
    .fits(fits[RES_SMEM]), .short(short[RES_SMEM]), .occ(occ_smem));

  ba_ledger #(.OW(RGW), .AW(DW), .CAP(REG_CAP)) u_reg (
    .clk(clk), .rst_n(rst_n), .add(req_regs), .sub(rel_regs),
    .do_add(do_add), .do_sub(do_sub),
    .fits(fits[RES_REG]), .short(short[RES_REG]), .occ(occ_regs));

  ba_ledger #(.OW(BKW), .AW(1), .CAP(BLK_CAP)) u_blk (
    .clk(clk), .rst_n(rst_n), .add(1'b1), .sub(1'b1),
    .do_add(do_add), .do_sub(do_sub),
    .fits(fits[RES_BLK]), .short(short[RES_BLK]), .occ(occ_blocks));

  always_ff @(posedge clk) begin
    if (!rst_n) err_underflow <= 1'b0;
    else        err_underflow <= err_underflow | rel_bad;
  end
endmodule

// File: rtl/ba_chk.sv
module ba_chk #(
  parameter int unsigned THREAD_CAP = 2048,
  parameter int unsigned SMEM_CAP   = 65536,
  parameter int unsigned REG_CAP    = 65536,
  parameter int unsigned BLK_CAP    = 32,
  parameter int unsigned TCW = 12,
  parameter int unsigned SMW = 17,
  parameter int unsigned RGW = 17,
  parameter int unsigned BKW = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_mode,
  input logic           slot_free,
  input logic           req_ok,
  input logic           rel_valid,
  input logic [TCW-1:0] occ_threads,
  input logic [SMW-1:0] occ_smem,
  input logic [RGW-1:0] occ_regs,
  input logic [BKW-1:0] occ_blocks,
  input logic           err_underflow
);
  // R2
  thr_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_threads) <= THREAD_CAP);
  // R4
  smem_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_smem) <= SMEM_CAP);
  // R5
  reg_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_regs) <= REG_CAP);
  // R6
  blk_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(occ_blocks) <= BLK_CAP);
  // R3
  slot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ok |-> slot_free);
  // R7
  idle_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !req_ok);
  // R7
  probe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_mode && !rel_valid) |=>
      ($stable(occ_threads) && $stable(occ_smem) && $stable(occ_regs) && $stable(occ_blocks)));
  // R8
  commit_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && req_mode && !rel_valid) |=> (occ_blocks == $past(occ_blocks) + BKW'(1)));
  // R10
  underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && occ_blocks == '0) |=> err_underflow);
  // R10
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_underflow |=> err_underflow);
endmodule

bind sm_block_admit ba_chk #(
  .THREAD_CAP(THREAD_CAP), .SMEM_CAP(SMEM_CAP), .REG_CAP(REG_CAP), .BLK_CAP(BLK_CAP),
  .TCW(TCW), .SMW(SMW), .RGW(RGW), .BKW(BKW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
  .slot_free(slot_free), .req_ok(req_ok), .rel_valid(rel_valid),
  .occ_threads(occ_threads), .occ_smem(occ_smem), .occ_regs(occ_regs),
  .occ_blocks(occ_blocks), .err_underflow(err_underflow)
);

// File: tb/sim_sm_block_admit.sv
`timescale 1ns/1ps
module sim_sm_block_admit;
  localparam int TCAP = 512, SCAP = 4096, RCAP = 8192, BCAP = 4;
  localparam int TCW = 10, SMW = 13, RGW = 14, BKW = 3, RPW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_mode = 0, slot_free = 0, rel_valid = 0;
  logic [TCW-1:0] req_threads = '0, rel_threads = '0;
  logic [SMW-1:0] req_smem = '0, rel_smem = '0;
  logic [RPW-1:0] req_rpt = '0, rel_rpt = '0;
  logic [TCW:0]   req_span;
  logic           req_ok, err_underflow;
  logic [TCW-1:0] occ_threads;
  logic [SMW-1:0] occ_smem;
  logic [RGW-1:0] occ_regs;
  logic [BKW-1:0] occ_blocks;

  int n_cmp = 0, n_bad = 0;
  int mt = 0, ms = 0, mr = 0, mb = 0, merr = 0;
  int pt[8], ps[8], pr[8];
  int pn = 0;

  always #5 clk = ~clk;

  sm_block_admit #(.WARP(32), .THREAD_CAP(TCAP), .SMEM_CAP(SCAP), .REG_CAP(RCAP),
                   .BLK_CAP(BCAP), .RPT_W(RPW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
    .req_threads(req_threads), .req_smem(req_smem), .req_rpt(req_rpt),
    .req_span(req_span), .slot_free(slot_free), .req_ok(req_ok),
    .rel_valid(rel_valid), .rel_threads(rel_threads), .rel_smem(rel_smem),
    .rel_rpt(rel_rpt), .occ_threads(occ_threads), .occ_smem(occ_smem),
    .occ_regs(occ_regs), .occ_blocks(occ_blocks), .err_underflow(err_underflow));

  function automatic int pad(int t);
    return ((t + 31) / 32) * 32;
  endfunction
  function automatic int rdem(int t, int r);
    return pad(t) * (((r + 3) / 4) * 4);
  endfunction
  function automatic bit fits(int t, int s, int r, bit sf);
    return sf && (mt + pad(t) <= TCAP) && (ms + s <= SCAP) &&
           (mr + rdem(t, r) <= RCAP) && (mb + 1 <= BCAP);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic show(string tag);
    chk(tag, "occ_threads", int'(occ_threads), mt);
    chk(tag, "occ_smem", int'(occ_smem), ms);
    chk(tag, "occ_regs", int'(occ_regs), mr);
    chk(tag, "occ_blocks", int'(occ_blocks), mb);
    chk(tag, "err_underflow", int'(err_underflow), merr);
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(string tag, bit v, bit m, int t, int s, int r, bit sf,
                      bit rv, int rt, int rs, int rr);
    bit ok;
    int nt, ns, nr, nb;
    req_valid = v; req_mode = m; req_threads = TCW'(t); req_smem = SMW'(s);
    req_rpt = RPW'(r); slot_free = sf;
    rel_valid = rv; rel_threads = TCW'(rt); rel_smem = SMW'(rs); rel_rpt = RPW'(rr);
    #1;
    ok = v && fits(t, s, r, sf);
    chk(tag, "req_ok", int'(req_ok), int'(ok));
    chk({tag, " R1"}, "req_span", int'(req_span), pad(t));
    nt = mt; ns = ms; nr = mr; nb = mb;
    if (ok && m) begin nt += pad(t); ns += s; nr += rdem(t, r); nb += 1; end
    if (rv) begin
      if (mt < pad(rt) || ms < rs || mr < rdem(rt, rr) || mb < 1) merr = 1;
      else begin nt -= pad(rt); ns -= rs; nr -= rdem(rt, rr); nb -= 1; end
    end
    @(posedge clk);
    mt = nt; ms = ns; mr = nr; mb = nb;
    @(negedge clk);
    req_valid = 0; rel_valid = 0;
    show(tag);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    show("R12 reset");

    // R1 padding at and just past a warp boundary
    step("R1 exact", 1, 0, 32, 0, 0, 1, 0, 0, 0, 0);
    step("R1 round", 1, 0, 33, 0, 0, 1, 0, 0, 0, 0);
    // R3 finder says no run
    step("R3 noslot", 1, 1, 32, 0, 0, 0, 0, 0, 0, 0);
    // R7 accepted probe leaves totals alone
    step("R7 probe", 1, 0, 64, 100, 8, 1, 0, 0, 0, 0);
    // R6 block-count limit, R8 commits, R9 releases
    for (int i = 0; i < 4; i++) step("R8 fill", 1, 1, 1, 0, 0, 1, 0, 0, 0, 0);
    step("R6 full", 1, 1, 1, 0, 0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R9 drain", 0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    // R4 shared memory exactly full
    step("R4 fit", 1, 1, 1, SCAP, 0, 1, 0, 0, 0, 0);
    step("R4 over", 1, 0, 1, 1, 0, 1, 0, 0, 0, 0);
    step("R9 smem", 0, 0, 0, 0, 0, 1, 1, 1, SCAP, 0);
    // R5 register rounding and exact fit
    step("R5 fit", 1, 1, 64, 0, 125, 1, 0, 0, 0, 0);
    step("R9 regs", 0, 0, 0, 0, 0, 1, 1, 64, 0, 125);
    step("R5 over", 1, 0, 65, 0, 128, 1, 0, 0, 0, 0);
    // R2 thread capacity
    step("R2 fill", 1, 1, 500, 0, 0, 1, 0, 0, 0, 0);
    step("R2 over", 1, 0, 1, 0, 0, 1, 0, 0, 0, 0);
    step("R9 thr", 0, 0, 0, 0, 0, 1, 1, 500, 0, 0);
    // R11 commit and release in one cycle
    step("R11 a", 1, 1, 64, 10, 4, 1, 0, 0, 0, 0);
    step("R11 both", 1, 1, 32, 20, 8, 1, 1, 64, 10, 4);
    step("R11 drain", 0, 0, 0, 0, 0, 1, 1, 32, 20, 8);

    // constrained random: R2 R3 R4 R5 R6 R7 R8 R9 R11
    for (int k = 0; k < 2000; k++) begin
      bit v, m, sf, rv, ok;
      int t, s, r, rt, rs, rr;
      v = ($urandom_range(0, 5) != 0); m = $urandom_range(0, 1);
      sf = ($urandom_range(0, 7) != 0);
      t = $urandom_range(1, 300); s = $urandom_range(0, 2000); r = $urandom_range(0, 40);
      rv = (pn > 0) && ($urandom_range(0, 2) == 0);
      rt = 0; rs = 0; rr = 0;
      if (rv) begin
        int idx;
        idx = $urandom_range(0, pn - 1);
        rt = pt[idx]; rs = ps[idx]; rr = pr[idx];
        pn--; pt[idx] = pt[pn]; ps[idx] = ps[pn]; pr[idx] = pr[pn];
      end
      ok = v && m && fits(t, s, r, sf);
      step("rand R8 R9", v, m, t, s, r, sf, rv, rt, rs, rr);
      if (ok) begin pt[pn] = t; ps[pn] = s; pr[pn] = r; pn++; end
    end
    while (pn > 0) begin
      pn--;
      step("R9 final", 0, 0, 0, 0, 0, 1, 1, pt[pn], ps[pn], pr[pn]);
    end

    // R10 underflow on an empty core, then stickiness
    step("R10 under", 0, 0, 0, 0, 0, 1, 1, 1, 0, 0);
    step("R10 sticky", 1, 1, 32, 0, 0, 1, 0, 0, 0, 0);
    step("R10 hold", 0, 0, 0, 0, 0, 1, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule